// File: doc/BRIEF.md
# Reset Release and First-Fetch Sequencer

This block takes an asynchronous active-low reset pin and turns it into an internal reset. The internal reset asserts at once, without waiting for a clock edge. Its release is synchronized to the fast clock. The block runs on a clock at twice the processor bus clock and derives the bus clock itself. It can therefore time the first instruction fetch in half bus periods. Thirteen fast edges after the internal reset releases, which is 6.5 bus periods, it emits a single-cycle fetch-start strobe. The strobe carries the fixed start address FFFF0h.

The block also captures a bus-configuration strap on the first fast edge after release. A captured high lets each address region's own demultiplex bit decide whether that region puts its address only on the dedicated address pins. A captured low forces every region to multiplex address and data, whatever its bit says. The pin has a weak pull-up on the board, so an open strap selects per-region control. The block sits between the reset pad and the processor core's fetch unit and bus interface.

Top module: `boot_seq_ctrl`

## Requirements
- R1: While `rst_n_i` is low, `int_rst_n_o` is low without any clock edge. During that time `fetch_o`, `fetch_addr_o`, `bus_mode_o`, `clkout_o` and `region_demux_o` are all zero.
- R2: After `rst_n_i` rises, `int_rst_n_o` goes high on exactly the second rising edge of `clk_i`.
- R3: `clkout_o` stays low until the internal reset releases. From then on it inverts on every `clk_i` edge, so it is high after the first edge that follows release.
- R4: `fetch_o` is high for exactly one `clk_i` cycle. It rises on the 13th `clk_i` edge after the release edge, which is 6.5 periods of `clkout_o`, and `clkout_o` is high during that cycle.
- R5: `fetch_addr_o` equals 20'hFFFF0 while `fetch_o` is high and is zero at all other times.
- R6: `fetch_o` does not rise again until a new reset occurs.
- R7: `strap_i` is captured into `bus_mode_o` on the first `clk_i` edge after the release edge. Changes to `strap_i` before or after that edge have no effect on `bus_mode_o`.
- R8: When `bus_mode_o` is 1, bit i of `region_demux_o` equals bit i of `region_da_i` (region i). When `bus_mode_o` is 0, all bits of `region_demux_o` are 0.
- R9: A reset that arrives partway through the count cancels the pending fetch. The next release starts the full sequence again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, twice the bus clock rate |
| rst_n_i | input | 1 | Asynchronous active-low reset pin |
| strap_i | input | 1 | Bus-configuration strap (board pull-up reads high) |
| region_da_i | input | NREG | Per-region demultiplex bit from the region registers |
| int_rst_n_o | output | 1 | Internal reset, synchronized release |
| clkout_o | output | 1 | Derived bus clock, half of `clk_i` |
| fetch_o | output | 1 | One-cycle first-fetch start strobe |
| fetch_addr_o | output | ADDR_W | First fetch address, valid with `fetch_o` |
| bus_mode_o | output | 1 | Latched strap: 1 per-region control, 0 forced multiplex |
| region_demux_o | output | NREG | Effective per-region demultiplex enable |

## Verification
The assertions assume that `rst_n_i` rises at least half a nanosecond clear of the next rising edge of `clk_i`. They also assume that `strap_i` is steady across the capture edge. The synchronizer latency they check relies on those two conditions. The bench always releases reset at a fixed offset inside a clock cycle, and it sweeps that offset over several phases. It changes the strap only at falling edges. It drives the wrong level up to the half cycle before the capture edge and again straight after it, so only a capture on the specified edge yields the expected mode.

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int FETCH_HALF  = 13,
  parameter int ADDR_W      = 20,
  parameter logic [ADDR_W-1:0] RESET_VEC = 20'hFFFF0,
  parameter int NREG        = 4
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              strap_i,
  input  logic [NREG-1:0]   region_da_i,
  output logic              int_rst_n_o,
  output logic              clkout_o,
  output logic              fetch_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              bus_mode_o,
  output logic [NREG-1:0]   region_demux_o
);
  localparam int CNT_W = $clog2(FETCH_HALF + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FETCH_HALF);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(FETCH_HALF - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   fetch_q, clk_q, strap_q, strap_done_q;

  always_ff @(posedge clk_i or negedge rst_n_i)
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};

  assign int_rst_n_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge int_rst_n_o)
    if (!int_rst_n_o) begin
      cnt_q   <= '0;
      fetch_q <= 1'b0;
      clk_q   <= 1'b0;
    end else begin
      clk_q   <= ~clk_q;
      fetch_q <= (cnt_q == CNT_PRE);
      if (cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
    end

  always_ff @(posedge clk_i or negedge int_rst_n_o)
    if (!int_rst_n_o) begin
      strap_q      <= 1'b0;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q) begin
      strap_q      <= strap_i;
      strap_done_q <= 1'b1;
    end

  assign clkout_o       = clk_q;
  assign fetch_o        = fetch_q;
  assign fetch_addr_o   = fetch_q ? RESET_VEC : '0;
  assign bus_mode_o     = strap_q;
  assign region_demux_o = strap_q ? region_da_i : '0;

  // R1
  rst_hold_chk: assert property (@(posedge clk_i)
    !rst_n_i |-> (!int_rst_n_o && !fetch_o && !clkout_o));

  // R2
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(int_rst_n_o) |-> ($past(rst_n_i) && $past(rst_n_i, 2)));

  // R3
  clk_toggle_chk: assert property (@(posedge clk_i) disable iff (!int_rst_n_o)
    $past(int_rst_n_o) |-> (clkout_o != $past(clkout_o)));

  // R4
  fetch_phase_chk: assert property (@(posedge clk_i) disable iff (!int_rst_n_o)
    fetch_o |-> (clkout_o && strap_done_q));

  // R6
  fetch_once_chk: assert property (@(posedge clk_i) disable iff (!int_rst_n_o)
    fetch_o |=> !fetch_o);

  // R7
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!int_rst_n_o)
    (strap_done_q && $past(strap_done_q)) |-> $stable(bus_mode_o));
endmodule

// File: tb/boot_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module boot_seq_ctrl_tb_top;
  localparam logic [19:0] VEC = 20'hFFFF0;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b1;
  logic [3:0] da = '0;
  logic int_rst_n, clkout, fetch, bus_mode;
  logic [19:0] faddr;
  logic [3:0] demux;
  int tests = 0, failed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  boot_seq_ctrl dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .strap_i(strap), .region_da_i(da),
    .int_rst_n_o(int_rst_n), .clkout_o(clkout), .fetch_o(fetch),
    .fetch_addr_o(faddr), .bus_mode_o(bus_mode), .region_demux_o(demux));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic trial(input bit want, input real ph, input logic [3:0] pat, input bit abort);
    int n, nf, fat;
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk(int_rst_n == 1'b0, "R1 async assert", int_rst_n, 0);
    da = pat;
    strap = ~want;
    repeat (3) @(negedge clk);
    chk({fetch, faddr, bus_mode, clkout, demux} == '0, "R1 reset outputs",
        {fetch, faddr, bus_mode, clkout, demux}, 0);
    @(posedge clk);
    #(ph);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!int_rst_n && n < 10);
    chk(n == 2, "R2 release latency", n, 2);
    chk(clkout == 1'b0, "R3 clkout at release", clkout, 0);
    strap = want;
    nf = 0; fat = -1;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (k == 1) strap = ~want;
      if (abort && k == 7) begin
        rst_n = 1'b0;
        #0.5;
        chk(int_rst_n == 1'b0, "R9 mid-count reset", int_rst_n, 0);
        break;
      end
      chk(clkout == k[0], "R3 clkout toggle", clkout, k[0]);
      if (fetch) begin
        nf++;
        if (fat < 0) fat = k;
        chk(faddr == VEC, "R5 vector", faddr, VEC);
        chk(clkout == 1'b1, "R4 clkout high at fetch", clkout, 1);
      end else begin
        chk(faddr == '0, "R5 address idle", faddr, 0);
      end
    end
    if (abort) begin
      repeat (20) begin
        @(negedge clk);
        if (fetch) nf++;
      end
      chk(nf == 0, "R9 fetch cancelled", nf, 0);
    end else begin
      chk(fat == 13, "R4 fetch delay in half periods", fat, 13);
      chk(nf == 1, "R6 single pulse", nf, 1);
      chk(bus_mode == want, "R7 strap capture edge", bus_mode, want);
      chk(demux == (want ? pat : 4'h0), "R8 region demux", demux, want ? pat : 4'h0);
      da = ~pat;
      #0.5;
      chk(demux == (want ? ~pat : 4'h0), "R8 region demux follow", demux, want ? ~pat : 4'h0);
    end
  endtask

  initial begin
    real phs[5] = '{0.5, 1.2, 2.0, 3.1, 4.4};
    repeat (3) @(negedge clk);
    chk(int_rst_n == 1'b0 && fetch == 1'b0, "R1 power-up reset", {int_rst_n, fetch}, 0);
    for (int w = 0; w < 2; w++)
      for (int p = 0; p < 5; p++)
        trial(w[0], phs[p], 4'((p * 5 + w * 3 + 1) & 15), 1'b0);
    trial(1'b1, 1.0, 4'hA, 1'b1);
    trial(1'b1, 1.0, 4'h5, 1'b0);
    trial(1'b0, 3.5, 4'hF, 1'b1);
    trial(1'b0, 3.5, 4'hF, 1'b0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule